// File: doc/BRIEF.md
# Masked Five-Tuple Flow Classifier

This block sorts IPv4 packets into flows. Upstream logic extracts the header fields and a content scanner reports which payload pattern lists the packet hit. Together they form a 112-bit search key. The block compares that key against a small table of rules. Each rule has a value word, a care mask and a 16-bit flow identifier.

All rules are evaluated in the same cycle. When several rules hit, the lowest-numbered one wins. Its flow identifier is returned, together with a hit flag and a drop flag for the packet handling logic downstream.

Software or a control engine loads the rules one at a time through a write port. Each write carries an index, value, mask, flow identifier and an enable bit. Writing a rule with its enable bit cleared retires that rule. One lookup can be issued per clock. Its result appears on registered outputs one cycle later.

Top module: `hdrcls_classifier`

## Requirements
- R1: The key is packed with the source IPv4 address in bits [111:80], the destination address in [79:48], the source port in [47:32], the destination port in [31:16], the protocol in [15:8] and the content vector in [7:0]. In the content vector, bit 0 flags the general-spam list and bit 1 flags the money-saving-spam list.
- R2: A rule hits when every key bit whose mask bit is 1 equals the rule's value bit. Key bits under a mask bit of 0 are ignored.
- R3: When more than one rule hits, the rule with the lowest index supplies the flow identifier.
- R4: A rule whose enable bit is 0 never hits. Reset clears every enable bit, so an empty table misses every key.
- R5: A lookup presented with `key_valid` high produces `res_valid` high on the following cycle, and only then.
- R6: On a lookup that hits no rule, `res_hit` is 0 and `res_flow` is 0.
- R7: `res_drop` is high exactly when a result hits a rule.
- R8: A rule write applies to lookups presented in later cycles. A lookup presented in the same cycle as a write still sees the previous table contents.
- R9: In any cycle where `res_valid` is low, `res_hit`, `res_drop` and `res_flow` are all 0.
- R10: While `rst` is high, all outputs are 0. After reset, the table holds no enabled rule.
- R11: Take a packet 80FC0505 to 8D8E0202, ports 0x1000 to 0x0050, protocol 0x06 and content 0x03. It hits a rule with value 80FC0000/8D8E0000/0000/0050/06/01 and mask FFFF0000/FFFF0000/0000/FFFF/FF/01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one rule this cycle |
| wr_idx | input | IDX_W | Rule index to write |
| wr_enable | input | 1 | Enable bit stored with the rule |
| wr_value | input | KEY_W | Rule value word |
| wr_mask | input | KEY_W | Rule care mask (1 = compare) |
| wr_flow | input | FLOW_W | Flow identifier returned on a hit |
| key_valid | input | 1 | A lookup key is presented |
| key | input | KEY_W | Search key |
| res_valid | output | 1 | Result of the previous cycle's lookup |
| res_hit | output | 1 | Some enabled rule hit |
| res_flow | output | FLOW_W | Flow identifier of the winning rule |
| res_drop | output | 1 | Packet is flagged for discard |

## Verification
Four properties are checked on every cycle:
- the one-cycle result strobe, which follows `key_valid` and nothing else;
- the zeroed outputs whenever no result is due;
- the zero flow identifier on a miss, and the drop flag tracking the hit flag;
- no hit before any rule has been enabled since reset.

Some behaviour can only be shown by the bench's scenarios, because it depends on table contents that the assertions do not model:
- the masked bit comparison on each header field and on the content vector;
- the lowest-index priority among overlapping rules;
- retiring a rule;
- the ordering of a write against a lookup in the same cycle.

// File: rtl/hdrcls_pkg.sv
package hdrcls_pkg;
  localparam int IP_W    = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int CVEC_W  = 8;
  localparam int KEY_W   = 2 * IP_W + 2 * PORT_W + PROTO_W + CVEC_W;

  // Content vector list flags (R1)
  localparam int CV_GENERAL = 0;
  localparam int CV_SAVINGS = 1;

  typedef struct packed {
    logic [IP_W-1:0]    src_ip;
    logic [IP_W-1:0]    dst_ip;
    logic [PORT_W-1:0]  src_port;
    logic [PORT_W-1:0]  dst_port;
    logic [PROTO_W-1:0] proto;
    logic [CVEC_W-1:0]  cvec;
  } hdr_key_t;
endpackage

// File: rtl/hdrcls_table.sv
module hdrcls_table #(
  parameter int N      = 8,
  parameter int KEY_W  = 112,
  parameter int FLOW_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_enable,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic [KEY_W-1:0]  key,
  output logic [N-1:0]      hit_vec,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FLOW_W-1:0] rd_flow
);
  logic [KEY_W-1:0]  val_q  [N];
  logic [KEY_W-1:0]  msk_q  [N];
  logic [FLOW_W-1:0] flow_q [N];
  logic [N-1:0]      ena_q;

  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_idx) < N);

  // Rule words carry no reset; only the enable bits do.
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      val_q[wr_idx]  <= wr_value;
      msk_q[wr_idx]  <= wr_mask;
      flow_q[wr_idx] <= wr_flow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
    end else if (wr_ok) begin
      ena_q[wr_idx] <= wr_enable;
    end
  end

  // One masked comparator per rule, all evaluated in parallel.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ena_q[g] && (((key ^ val_q[g]) & msk_q[g]) == '0);
  end

  assign rd_flow = (int'(rd_idx) < N) ? flow_q[rd_idx] : '0;
endmodule

// File: rtl/hdrcls_prio.sv
module hdrcls_prio #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/hdrcls_classifier.sv
module hdrcls_classifier #(
  parameter int N      = 8,
  parameter int KEY_W  = hdrcls_pkg::KEY_W,
  parameter int FLOW_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_enable,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [FLOW_W-1:0] res_flow,
  output logic              res_drop
);
  logic [N-1:0]      hit_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic [FLOW_W-1:0] win_flow;

  hdrcls_table #(.N(N), .KEY_W(KEY_W), .FLOW_W(FLOW_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_enable (wr_enable),
    .wr_value  (wr_value),
    .wr_mask   (wr_mask),
    .wr_flow   (wr_flow),
    .key       (key),
    .hit_vec   (hit_vec),
    .rd_idx    (win_idx),
    .rd_flow   (win_flow)
  );

  hdrcls_prio #(.N(N)) u_prio (
    .req (hit_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_flow  <= '0;
      res_drop  <= 1'b0;
    end else begin
      res_valid <= key_valid;
      if (key_valid && any_hit) begin
        res_hit  <= 1'b1;
        res_flow <= win_flow;
        res_drop <= 1'b1;
      end else begin
        res_hit  <= 1'b0;
        res_flow <= '0;
        res_drop <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdrcls_chk.sv
module hdrcls_chk #(
  parameter int FLOW_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_enable,
  input logic              key_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic [FLOW_W-1:0] res_flow,
  input logic              res_drop
);
  // Set once any rule has been enabled since the last reset.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (wr_en && wr_enable) armed_q <= 1'b1;
  end

  a_r5_result_follows_key: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> res_valid);
  a_r5_no_spurious_result: assert property (@(posedge clk) disable iff (rst)
    !key_valid |=> !res_valid);
  a_r6_miss_zero_flow: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_flow == '0));
  a_r7_drop_tracks_hit: assert property (@(posedge clk) disable iff (rst)
    res_drop == res_hit);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_drop && res_flow == '0));
  a_r4_empty_never_hits: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !res_hit);
endmodule

bind hdrcls_classifier hdrcls_chk #(.FLOW_W(FLOW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_enable (wr_enable),
  .key_valid (key_valid),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_flow  (res_flow),
  .res_drop  (res_drop)
);

// File: tb/test_hdrcls_classifier.sv
`timescale 1ns/1ps
module test_hdrcls_classifier;
  import hdrcls_pkg::*;

  localparam int N  = 8;
  localparam int FW = 16;
  localparam int IW = 3;

  typedef struct packed {
    hdr_key_t    k;
    logic        hit;
    logic [15:0] flow;
  } vec_t;

  // E0 sample rule (0A01), E1 dport 443 (0B02), E5 UDP (0D05), E7 savings list (0E07)
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{k:'{32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h03}, hit:1'b1, flow:16'h0A01},
    '{k:'{32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h02}, hit:1'b1, flow:16'h0E07},
    '{k:'{32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01}, hit:1'b0, flow:16'h0000},
    '{k:'{32'h0A000001, 32'h0A000002, 16'h2222, 16'h01BB, 8'h11, 8'h00}, hit:1'b1, flow:16'h0B02},
    '{k:'{32'h0A000001, 32'h0A000002, 16'h2222, 16'h0035, 8'h11, 8'h00}, hit:1'b1, flow:16'h0D05},
    '{k:'{32'h00000000, 32'h00000000, 16'h0000, 16'h0000, 8'h00, 8'h00}, hit:1'b0, flow:16'h0000},
    '{k:'{32'h80FC1234, 32'h8D8E9999, 16'hFFFF, 16'h0050, 8'h06, 8'h01}, hit:1'b1, flow:16'h0A01},
    '{k:'{32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0051, 8'h06, 8'h01}, hit:1'b0, flow:16'h0000}
  };

  logic           clk = 1'b0;
  logic           rst;
  logic           wr_en, wr_enable, key_valid;
  logic [IW-1:0]  wr_idx;
  logic [KEY_W-1:0] wr_value, wr_mask, key;
  logic [FW-1:0]  wr_flow;
  logic           res_valid, res_hit, res_drop;
  logic [FW-1:0]  res_flow;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hdrcls_classifier #(.N(N), .FLOW_W(FW)) i_hdrcls_classifier (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_enable(wr_enable),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_flow(wr_flow),
    .key_valid(key_valid), .key(key), .res_valid(res_valid), .res_hit(res_hit),
    .res_flow(res_flow), .res_drop(res_drop)
  );

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_result(string tag, logic hit_e, logic [15:0] flow_e);
    expect_eq({tag, " valid"}, 32'(res_valid), 32'd1);
    expect_eq({tag, " hit"},   32'(res_hit),   32'(hit_e));
    expect_eq({tag, " drop"},  32'(res_drop),  32'(hit_e));
    expect_eq({tag, " flow"},  32'(res_flow),  32'(flow_e));
  endtask

  task automatic put(int idx, logic ena, hdr_key_t v, hdr_key_t m, logic [15:0] f);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_enable = ena;
    wr_value = v; wr_mask = m; wr_flow = f;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(hdr_key_t k);
    @(negedge clk);
    key_valid = 1'b1; key = k;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  localparam hdr_key_t SAMPLE = '{32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h03};
  localparam hdr_key_t ZERO   = '0;

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_enable = 1'b0;
    wr_value = '0; wr_mask = '0; wr_flow = '0; key_valid = 1'b0; key = '0;
    repeat (3) @(negedge clk);
    // R10: outputs zero under reset
    expect_eq("R10 valid in reset", 32'(res_valid), 32'd0);
    expect_eq("R10 flow in reset",  32'(res_flow),  32'd0);
    rst = 1'b0;

    // R4/R10: empty table misses the sample packet
    look(SAMPLE);
    expect_result("R4 empty table", 1'b0, 16'h0000);
    @(negedge clk);
    // R9: no lookup, quiet outputs
    expect_eq("R9 idle valid", 32'(res_valid), 32'd0);
    expect_eq("R9 idle hit",   32'(res_hit),   32'd0);

    // R11 rule, plus overlapping rules for R2/R3
    put(0, 1'b1, '{32'h80FC0000, 32'h8D8E0000, 16'h0000, 16'h0050, 8'h06, 8'h01},
                 '{32'hFFFF0000, 32'hFFFF0000, 16'h0000, 16'hFFFF, 8'hFF, 8'h01}, 16'h0A01);
    put(1, 1'b1, '{32'h0, 32'h0, 16'h0, 16'h01BB, 8'h00, 8'h00},
                 '{32'h0, 32'h0, 16'h0, 16'hFFFF, 8'h00, 8'h00}, 16'h0B02);
    put(5, 1'b1, '{32'h0, 32'h0, 16'h0, 16'h0, 8'h11, 8'h00},
                 '{32'h0, 32'h0, 16'h0, 16'h0, 8'hFF, 8'h00}, 16'h0D05);
    put(7, 1'b1, '{32'h0, 32'h0, 16'h0, 16'h0, 8'h00, 8'h02},
                 '{32'h0, 32'h0, 16'h0, 16'h0, 8'h00, 8'h02}, 16'h0E07);

    // R1 R2 R3 R6 R7 R11: vector table
    for (int i = 0; i < NV; i++) begin
      look(VECS[i].k);
      expect_result($sformatf("R2/R3/R6/R7/R11 vec%0d", i), VECS[i].hit, VECS[i].flow);
    end

    // R8: write catch-all rule 2 while a lookup of ZERO runs in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd2; wr_enable = 1'b1;
    wr_value = '0; wr_mask = '0; wr_flow = 16'h0C03;
    key_valid = 1'b1; key = ZERO;
    @(negedge clk);
    wr_en = 1'b0;
    expect_result("R8 same-cycle sees old table", 1'b0, 16'h0000);
    @(negedge clk);
    key_valid = 1'b0;
    expect_result("R8 next lookup sees new rule", 1'b1, 16'h0C03);

    // R4: retire rule 0; rule 2 (catch-all) now outranks rule 7
    put(0, 1'b0, '0, '0, 16'h0000);
    look(SAMPLE);
    expect_result("R4 retired rule", 1'b1, 16'h0C03);

    // R10: reset mid-run empties the table
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    look(SAMPLE);
    expect_result("R10 table cleared", 1'b0, 16'h0000);

    summary();
  end
endmodule